// File: doc/BRIEF.md
# Per-Core Event Timer with Free-Running Count

This block gives one processor core a time base and a single programmable wake-up. A counter runs without pause from reset, one step per clock, and wraps to zero after its top value. Software reads it as two words, the upper part and the lower part. It reads upper, lower and upper again, and keeps the pair when both upper reads agree. Nothing is latched when a half is read, so each read returns the live count.

Next to the counter sits a one-shot countdown. Software writes a tick delta to the load register, and with the enable bit set the countdown runs down to expiry. On expiry it sets a sticky status flag, which is also the level interrupt to the core. The countdown then stays idle until the load register is written again. The register port is a plain synchronous one: one select, one write strobe, write data and registered read data.

Top module: `evtimer_core`

## Requirements
- R1: While reset is high and in the first cycle after it, the control register reads 0, the status flag is clear, the count is 0, the interrupt is low and the read data is 0.
- R2: The count rises by exactly one every clock and wraps to 0 after 2^CNT_W-1. Writes to any index never change it. Writes to the count indices 2 and 3 have no effect.
- R3: Read data is registered. After a clock edge it shows the register chosen by the select before that edge, with the state from before that edge. Index 2 returns count bits CNT_W-1 down to WORD_W, zero-extended. Index 3 returns count bits WORD_W-1 down to 0.
- R4: Reading a half does not freeze the count. Two reads of index 3 in back-to-back cycles differ by exactly one.
- R5: A write of delta D to index 6 arms the countdown. With enable set, the status flag and the interrupt rise at the D-th clock edge after the write edge. D=0 acts as D=1. Index 6 reads back the last value written.
- R6: Bit 0 of index 0 is the enable. Index 0 reads back that bit alone in bit 0. Writing bit 0 = 0 stops the countdown and disarms it, including in the expiry cycle. No event follows, even after enable is set again, until index 6 is written.
- R7: Index 1 reads the status flag in bit 0, and the interrupt equals that flag. A write to index 1 with bit 0 = 0 clears it. A write with bit 0 = 1 leaves it unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R8: A write to index 6 while a countdown is running replaces the remaining count and raises no event, even in the cycle that would have expired.
- R9: After an expiry, no further event occurs until index 6 is written again.
- R10: Indices 4, 5 and 7 read 0. Writes to them change no register.
- R11: A write to index 6 while enable is 0 arms the countdown without running it. Counting starts with the edge after enable is set, so expiry comes D edges after the enable write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count steps on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the selected index |
| reg_sel | input | 3 | Register index |
| reg_wdata | input | WORD_W | Write data |
| reg_rdata | output | WORD_W | Registered read data for the index selected in the previous cycle |
| irq | output | 1 | Level interrupt, high while the status flag is set |

## Verification
The hardest cases to reach are the count wrap and the carry from the lower word into the upper word. With 56 bits, neither can be reached by running the clock. The bench therefore runs a second copy with a 14-bit count split into 8-bit words. That copy wraps within about sixteen thousand cycles, and its upper word is watched until it steps from its top value back to zero.

The other hard cases are collisions in the expiry cycle itself: a reload, a stop or a status clear that lands on the same edge as the expiry. The bench times these writes edge-exact from the moment the load is written.

// File: rtl/evt_pkg.sv
`timescale 1ns/1ps
package evt_pkg;

    localparam int IDX_W = 3;

    localparam logic [IDX_W-1:0] IDX_CTRL   = 3'd0;
    localparam logic [IDX_W-1:0] IDX_STAT   = 3'd1;
    localparam logic [IDX_W-1:0] IDX_CNT_HI = 3'd2;
    localparam logic [IDX_W-1:0] IDX_CNT_LO = 3'd3;
    localparam logic [IDX_W-1:0] IDX_LOAD   = 3'd6;

    // One strobe per writable register.
    typedef struct packed {
        logic ctrl;
        logic stat;
        logic load;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_wr(input logic wr, input logic [IDX_W-1:0] sel);
        wr_strobe_t s;
        s.ctrl = wr && (sel == IDX_CTRL);
        s.stat = wr && (sel == IDX_STAT);
        s.load = wr && (sel == IDX_LOAD);
        return s;
    endfunction

    function automatic logic is_mapped(input logic [IDX_W-1:0] sel);
        return (sel == IDX_CTRL) || (sel == IDX_STAT) || (sel == IDX_CNT_HI) ||
               (sel == IDX_CNT_LO) || (sel == IDX_LOAD);
    endfunction

endpackage

// File: rtl/evt_freerun.sv
`timescale 1ns/1ps
module evt_freerun #(
    parameter int CNT_W = 56
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    // Wraps naturally modulo 2^CNT_W.
    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + CNT_W'(1);
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/evt_countdown.sv
`timescale 1ns/1ps
module evt_countdown #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              load_i,
    input  logic              stop_i,
    input  logic [WORD_W-1:0] val_i,
    output logic              armed_o,
    output logic              fire_o
);
    logic [WORD_W-1:0] remain_q;
    logic              armed_q;
    logic              last_tick;

    // A remaining count of one or zero expires on the next running edge.
    assign last_tick = (remain_q <= WORD_W'(1));
    assign fire_o    = armed_q && en_i && last_tick && !load_i && !stop_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            armed_q  <= 1'b0;
        end else if (load_i) begin
            remain_q <= val_i;
            armed_q  <= 1'b1;
        end else if (stop_i || fire_o) begin
            armed_q  <= 1'b0;
        end else if (armed_q && en_i) begin
            remain_q <= remain_q - WORD_W'(1);
        end
    end

    assign armed_o = armed_q;
endmodule

// File: rtl/evt_regs.sv
`timescale 1ns/1ps
module evt_regs
    import evt_pkg::*;
#(
    parameter int CNT_W  = 56,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_strobe_t        stb_i,
    input  logic [IDX_W-1:0]  sel_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              fire_i,
    output logic              en_o,
    output logic              flag_o,
    output logic [WORD_W-1:0] rdata_o
);
    localparam int HI_W = CNT_W - WORD_W;

    logic              en_q;
    logic              flag_q;
    logic [WORD_W-1:0] load_q;
    logic [WORD_W-1:0] rdata_q;
    logic [WORD_W-1:0] hi_word;
    logic [WORD_W-1:0] lo_word;
    logic [WORD_W-1:0] rd_mux;

    generate
        if (HI_W > 0) begin : g_split
            assign hi_word = WORD_W'(cnt_i[CNT_W-1:WORD_W]);
            assign lo_word = cnt_i[WORD_W-1:0];
        end else begin : g_narrow
            assign hi_word = '0;
            assign lo_word = WORD_W'(cnt_i);
        end
    endgenerate

    always_comb begin
        case (sel_i)
            IDX_CTRL:   rd_mux = WORD_W'(en_q);
            IDX_STAT:   rd_mux = WORD_W'(flag_q);
            IDX_CNT_HI: rd_mux = hi_word;
            IDX_CNT_LO: rd_mux = lo_word;
            IDX_LOAD:   rd_mux = load_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            flag_q  <= 1'b0;
            load_q  <= '0;
            rdata_q <= '0;
        end else begin
            rdata_q <= rd_mux;
            if (stb_i.ctrl) en_q <= wdata_i[0];
            if (stb_i.load) load_q <= wdata_i;
            // Expiry wins over a same-cycle clear.
            if (fire_i)                        flag_q <= 1'b1;
            else if (stb_i.stat && !wdata_i[0]) flag_q <= 1'b0;
        end
    end

    assign en_o    = en_q;
    assign flag_o  = flag_q;
    assign rdata_o = rdata_q;
endmodule

// File: rtl/evtimer_core.sv
`timescale 1ns/1ps
module evtimer_core
    import evt_pkg::*;
#(
    parameter int CNT_W  = 56,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq
);
    wr_strobe_t       wstb;
    logic             stop_req;
    logic [CNT_W-1:0] cnt_q;
    logic             ctrl_en;
    logic             cd_armed;
    logic             cd_fire;

    assign wstb     = decode_wr(reg_wr, reg_sel);
    assign stop_req = wstb.ctrl && !reg_wdata[0];

    evt_freerun #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .cnt_o (cnt_q)
    );

    evt_countdown #(.WORD_W(WORD_W)) u_cd (
        .clk     (clk),
        .rst     (rst),
        .en_i    (ctrl_en),
        .load_i  (wstb.load),
        .stop_i  (stop_req),
        .val_i   (reg_wdata),
        .armed_o (cd_armed),
        .fire_o  (cd_fire)
    );

    evt_regs #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .stb_i   (wstb),
        .sel_i   (reg_sel),
        .wdata_i (reg_wdata),
        .cnt_i   (cnt_q),
        .fire_i  (cd_fire),
        .en_o    (ctrl_en),
        .flag_o  (irq),
        .rdata_o (reg_rdata)
    );
endmodule

// File: rtl/evt_checker.sv
`timescale 1ns/1ps
module evt_checker
    import evt_pkg::*;
#(
    parameter int CNT_W  = 56,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [2:0]        reg_sel,
    input logic [WORD_W-1:0] reg_wdata,
    input logic [WORD_W-1:0] reg_rdata,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt,
    input logic              en,
    input logic              armed
);
    logic live_q = 1'b0;

    always_ff @(posedge clk) live_q <= !rst;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!irq && !en && reg_rdata == '0));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        live_q |-> cnt == $past(cnt) + CNT_W'(1));

    // R7
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (live_q && $fell(irq)) |-> $past(reg_wr && reg_sel == IDX_STAT && !reg_wdata[0]));

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (live_q && $rose(irq)) |-> $past(armed && en));

    // R6
    stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !irq) |=> !irq);

    // R10
    unmapped_chk: assert property (@(posedge clk) disable iff (rst)
        !is_mapped(reg_sel) |=> reg_rdata == '0);
endmodule

bind evtimer_core evt_checker #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .cnt       (cnt_q),
    .en        (ctrl_en),
    .armed     (cd_armed)
);

// File: tb/evtimer_core_test.sv
`timescale 1ns/1ps
module evtimer_core_test;

    localparam longint unsigned CMASK [2] = '{(64'd1 << 56) - 1, (64'd1 << 14) - 1};
    localparam longint unsigned WMASK [2] = '{(64'd1 << 32) - 1, (64'd1 << 8) - 1};
    localparam int              WBITS [2] = '{32, 8};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0;
    logic [2:0]  sel = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rd_b;
    logic [7:0]  rd_s;
    logic        irq_b;
    logic        irq_s;

    evtimer_core #(.CNT_W(56), .WORD_W(32)) uut (
        .clk(clk), .rst(rst), .reg_wr(wr), .reg_sel(sel),
        .reg_wdata(wdata), .reg_rdata(rd_b), .irq(irq_b)
    );

    evtimer_core #(.CNT_W(14), .WORD_W(8)) uut_small (
        .clk(clk), .rst(rst), .reg_wr(wr), .reg_sel(sel),
        .reg_wdata(wdata[7:0]), .reg_rdata(rd_s), .irq(irq_s)
    );

    always #4 clk = ~clk;

    int  checks = 0;
    int  fails = 0;
    int  cyc_checks = 0;
    int  cyc_fails = 0;
    bit  done = 1'b0;

    // Behavioural reference, one entry per instance.
    longint unsigned m_cnt [2];
    longint unsigned m_rem [2];
    longint unsigned m_load [2];
    longint unsigned m_rd [2];
    bit              m_en [2];
    bit              m_arm [2];
    bit              m_flag [2];
    logic [2:0]      sel_q = 3'd0;

    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin : model
            longint unsigned wd;
            bit ld, stop, fire;
            wd = longint'(wdata) & WMASK[i];
            if (rst) begin
                m_cnt[i] = 0; m_rem[i] = 0; m_load[i] = 0; m_rd[i] = 0;
                m_en[i] = 0; m_arm[i] = 0; m_flag[i] = 0;
            end else begin
                case (sel)
                    3'd0:    m_rd[i] = m_en[i];
                    3'd1:    m_rd[i] = m_flag[i];
                    3'd2:    m_rd[i] = m_cnt[i] >> WBITS[i];
                    3'd3:    m_rd[i] = m_cnt[i] & WMASK[i];
                    3'd6:    m_rd[i] = m_load[i];
                    default: m_rd[i] = 0;
                endcase
                ld   = wr && sel == 3'd6;
                stop = wr && sel == 3'd0 && wd[0] == 1'b0;
                fire = m_arm[i] && m_en[i] && m_rem[i] <= 1 && !ld && !stop;
                m_cnt[i] = (m_cnt[i] + 1) & CMASK[i];
                if (ld) begin
                    m_load[i] = wd; m_rem[i] = wd; m_arm[i] = 1;
                end else if (stop || fire) begin
                    m_arm[i] = 0;
                end else if (m_arm[i] && m_en[i]) begin
                    m_rem[i] = m_rem[i] - 1;
                end
                if (wr && sel == 3'd0) m_en[i] = wd[0];
                if (fire) m_flag[i] = 1;
                else if (wr && sel == 3'd1 && wd[0] == 1'b0) m_flag[i] = 0;
            end
        end
        sel_q = sel;
    end

    function automatic string tag_of(input logic [2:0] s);
        case (s)
            3'd0:       return "R6";
            3'd1:       return "R7";
            3'd2, 3'd3: return "R3";
            3'd6:       return "R5";
            default:    return "R10";
        endcase
    endfunction

    // Every-clock comparison against the reference.
    always @(negedge clk) begin
        if (!rst && !done) begin
            cyc_checks += 4;
            if (rd_b != m_rd[0][31:0]) begin
                cyc_fails++;
                $display("FAIL %s big rdata sel=%0d actual=%h expected=%h", tag_of(sel_q), sel_q, rd_b, m_rd[0][31:0]);
            end
            if (rd_s != m_rd[1][7:0]) begin
                cyc_fails++;
                $display("FAIL %s small rdata sel=%0d actual=%h expected=%h", tag_of(sel_q), sel_q, rd_s, m_rd[1][7:0]);
            end
            if (irq_b != m_flag[0]) begin
                cyc_fails++;
                $display("FAIL R7 big irq actual=%0d expected=%0d", irq_b, m_flag[0]);
            end
            if (irq_s != m_flag[1]) begin
                cyc_fails++;
                $display("FAIL R7 small irq actual=%0d expected=%0d", irq_s, m_flag[1]);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint unsigned got, input longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] s, input logic [31:0] d);
        sel = s; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] s, output logic [31:0] b, output logic [7:0] sm);
        sel = s;
        @(negedge clk);
        b = rd_b; sm = rd_s;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic irq_is(input bit exp, input string tag, input string what);
        chk(irq_b == exp, tag, what, irq_b, exp);
    endtask

    initial begin
        logic [31:0] b, b2, h1, h2;
        logic [7:0]  s, s_prev;
        bit          seen_top;

        rst = 1'b1;
        idle(2);
        // R1: during reset
        chk(rd_b == 0, "R1", "rdata in reset", rd_b, 0);
        irq_is(0, "R1", "irq in reset");
        idle(1);
        rst = 1'b0;
        rd_reg(3'd0, b, s); chk(b == 0, "R1", "ctrl after reset", b, 0);
        rd_reg(3'd1, b, s); chk(b == 0, "R1", "status after reset", b, 0);
        rd_reg(3'd2, b, s); chk(b == 0, "R1", "count high after reset", b, 0);
        irq_is(0, "R1", "irq after reset");

        // R10: unmapped writes and reads
        wr_reg(3'd5, 32'hFFFF_FFFF);
        wr_reg(3'd7, 32'hFFFF_FFFF);
        rd_reg(3'd4, b, s); chk(b == 0, "R10", "index 4 read", b, 0);
        rd_reg(3'd5, b, s); chk(b == 0, "R10", "index 5 read", b, 0);
        rd_reg(3'd7, b, s); chk(b == 0, "R10", "index 7 read", b, 0);
        rd_reg(3'd0, b, s); chk(b == 0, "R10", "ctrl untouched", b, 0);
        rd_reg(3'd6, b, s); chk(b == 0, "R10", "load untouched", b, 0);
        irq_is(0, "R10", "irq untouched");

        // R2: writes to count indices are ignored (reference keeps counting)
        wr_reg(3'd2, 32'hFFFF_FFFF);
        wr_reg(3'd3, 32'h0);
        rd_reg(3'd2, b, s); chk(b == 0, "R2", "high after count write", b, 0);

        // R4: live low half, and high-low-high consistency (R3)
        rd_reg(3'd3, b, s);
        rd_reg(3'd3, b2, s);
        chk(b2 == b + 1, "R4", "low half steps between reads", b2, b + 1);
        rd_reg(3'd2, h1, s);
        rd_reg(3'd3, b, s);
        rd_reg(3'd2, h2, s);
        chk(h1 == h2 && h1 == 0, "R3", "high-low-high pair", h2, 0);

        // R6: enable readback holds bit 0 only
        wr_reg(3'd0, 32'hFFFF_FFFF);
        rd_reg(3'd0, b, s); chk(b == 1, "R6", "ctrl readback", b, 1);

        // R5: delta 5
        wr_reg(3'd6, 32'd5);
        idle(4); irq_is(0, "R5", "irq before 5th edge");
        idle(1); irq_is(1, "R5", "irq at 5th edge");
        rd_reg(3'd1, b, s); chk(b == 1, "R7", "status set", b, 1);
        rd_reg(3'd6, b, s); chk(b == 5, "R5", "load readback", b, 5);

        // R7: write 1 does nothing, write 0 clears
        wr_reg(3'd1, 32'd1); irq_is(1, "R7", "status write 1 keeps flag");
        wr_reg(3'd1, 32'd0); irq_is(0, "R7", "status write 0 clears");

        // R9: idle after expiry
        idle(20); irq_is(0, "R9", "no repeat event");

        // R7: clear in expiry cycle loses
        wr_reg(3'd6, 32'd3);
        idle(2);
        wr_reg(3'd1, 32'd0); irq_is(1, "R7", "expiry beats clear");
        wr_reg(3'd1, 32'd0);

        // R8: reload mid-run
        wr_reg(3'd6, 32'd10);
        idle(3);
        wr_reg(3'd6, 32'd9);
        idle(8); irq_is(0, "R8", "old count discarded");
        idle(1); irq_is(1, "R8", "new count expires");
        wr_reg(3'd1, 32'd0);

        // R8: reload in the expiry cycle
        wr_reg(3'd6, 32'd3);
        idle(2);
        wr_reg(3'd6, 32'd4); irq_is(0, "R8", "reload on expiry edge");
        idle(3); irq_is(0, "R8", "before reloaded expiry");
        idle(1); irq_is(1, "R8", "reloaded expiry");
        wr_reg(3'd1, 32'd0);

        // R5: delta zero acts as one
        wr_reg(3'd6, 32'd0); irq_is(0, "R5", "delta 0 before edge");
        idle(1); irq_is(1, "R5", "delta 0 after one edge");
        wr_reg(3'd1, 32'd0);

        // R6: stop mid-run then re-enable
        wr_reg(3'd6, 32'd8);
        idle(3);
        wr_reg(3'd0, 32'd0);
        idle(20); irq_is(0, "R6", "stopped countdown");
        wr_reg(3'd0, 32'd1);
        idle(20); irq_is(0, "R6", "re-enable without load");

        // R6: stop in the expiry cycle
        wr_reg(3'd6, 32'd2);
        idle(1);
        wr_reg(3'd0, 32'd0);
        idle(5); irq_is(0, "R6", "stop on expiry edge");
        wr_reg(3'd0, 32'd1);
        idle(10); irq_is(0, "R6", "still disarmed");

        // R11: load while disabled
        wr_reg(3'd0, 32'd0);
        wr_reg(3'd6, 32'd4);
        idle(10); irq_is(0, "R11", "no run while disabled");
        wr_reg(3'd0, 32'd1);
        idle(3); irq_is(0, "R11", "before expiry after enable");
        idle(1); irq_is(1, "R11", "expiry after enable");
        wr_reg(3'd1, 32'd0);

        // R2: wrap on the narrow copy, watched through its high word
        sel = 3'd2;
        seen_top = 1'b0;
        s_prev = 8'd0;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            s = rd_s;
            if (seen_top && s != 8'h3F) break;
            if (s == 8'h3F) seen_top = 1'b1;
            s_prev = s;
        end
        chk(seen_top && s == 8'h00, "R2", "small count wraps to zero", s, 0);
        rd_reg(3'd3, b, s);
        chk(s < 8'd8, "R2", "small low word near zero after wrap", s, 0);

        done = 1'b1;
        checks += cyc_checks;
        fails  += cyc_fails;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks + cyc_checks - fails - cyc_fails,
                     checks + cyc_checks + 1);
            $finish;
        end
    end

endmodule